// File: doc/BRIEF.md
# Multi-FIFO Interprocessor Mailbox

This block is a memory-mapped mailbox that lets several processors on a chip pass 32-bit words to each other. It holds a set of independent hardware queues, each four entries deep by default. A sender writes a word to a queue's message register to push it. A receiver reads the same register to pop the oldest word. For each queue, a full flag and a message count can be read over a simple single-cycle register bus. The bus has an address, a write strobe with write data, a read strobe, and read data that is valid in the same cycle as the address.

Each queue produces two events. A new-message event fires when a push makes the queue non-empty. A not-full event fires when a pop takes the queue out of the full state. Every user (processor) has its own bank of interrupt registers and sees both events of every queue: a latched status register, an enable register and one interrupt output. Status bits are acknowledged by writing 1 to them.

A parameter picks one of two interrupt register layouts:
- **Split layout:** separate enable-set and enable-clear registers.
- **Legacy layout:** software rewrites a single enable register directly.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset every queue is empty, every status and enable register reads 0, and every interrupt output is low. The revision register at offset 0x000 reads the constant parameter REV_ID, 32'h0000_0400 by default, and ignores writes.
- R2: A write to offset 0x040+4*m pushes the word into queue m. Reads of that offset return the queued words in the order they were written, removing one word per read.
- R3: A write to a queue that already holds DEPTH words is dropped, and the count stays DEPTH. A read of an empty queue returns 0 and leaves the count at 0.
- R4: Offset 0x080+4*m reads 1 when queue m holds DEPTH words and 0 otherwise.
- R5: Offset 0x0C0+4*m reads the number of words queued in queue m.
- R6: A push into an empty queue m sets bit 2*m (new message) in the status register of every user. A push into a non-empty queue sets no status bit.
- R7: A pop from a full queue m sets bit 2*m+1 (not full) in the status register of every user. A pop from a queue that is not full sets no status bit.
- R8: Writing a status register clears the bits written as 1 and keeps the bits written as 0. A read in the very next cycle shows the cleared value.
- R9: A user's interrupt output is high exactly one cycle after any bit is set in both its status and enable registers, and low one cycle after no such bit remains.
- R10: With the split layout (LAYOUT = LAYOUT_SPLIT), user u has status at 0x104+0x10*u, enable-set at 0x108+0x10*u and enable-clear at 0x10C+0x10*u. Writing 1 to a bit of enable-set sets that enable bit, and writing 1 to a bit of enable-clear clears it. Both offsets read back the enable register.
- R11: With the legacy layout (LAYOUT = LAYOUT_LEGACY), user u has status at 0x100+8*u and enable at 0x104+8*u. A write to the enable register replaces its whole value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW (12) | Byte address of the register access |
| we_i | input | 1 | Write strobe, one access per cycle |
| wdata_i | input | DW (32) | Write data |
| re_i | input | 1 | Read strobe; pops a queue when it addresses a message register; ignored while we_i is high |
| rdata_o | output | DW (32) | Read data for addr_i, valid in the same cycle |
| irq_o | output | N_USER (2) | Per-user interrupt outputs |

## Verification
A corrupt queue pointer shows on the very next pop as a word out of order or a stale word, and on the count register in the cycle after the bad update. A lost or doubled event latch shows when the status register is read on the access right after the triggering push or pop. A wrong enable mask or a stuck interrupt register shows on irq_o one cycle after the status or enable write that should have changed it. The bench sweeps every queue through fill, overflow, drain and underflow under both layouts, so each of these faults is read back within a few cycles of its cause.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic {
    LAYOUT_LEGACY = 1'b0,
    LAYOUT_SPLIT  = 1'b1
  } irq_layout_e;

  localparam int unsigned REV_OFF   = 'h000;
  localparam int unsigned MSG_BASE  = 'h040;
  localparam int unsigned FULL_BASE = 'h080;
  localparam int unsigned CNT_BASE  = 'h0C0;

  function automatic int unsigned stat_off(irq_layout_e l, int unsigned u);
    return (l == LAYOUT_SPLIT) ? ('h104 + 'h10 * u) : ('h100 + 8 * u);
  endfunction

  function automatic int unsigned en_off(irq_layout_e l, int unsigned u);
    return (l == LAYOUT_SPLIT) ? ('h108 + 'h10 * u) : ('h104 + 8 * u);
  endfunction

  function automatic int unsigned clr_off(int unsigned u);
    return 'h10C + 'h10 * u;
  endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          new_msg_o,
  output logic          not_full_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o     = (cnt_q == CW'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign do_push    = push_i && !full_o;
  assign do_pop     = pop_i && !empty_o;
  assign new_msg_o  = do_push && empty_o;
  assign not_full_o = do_pop && full_o;
  assign count_o    = cnt_q;
  assign rdata_o    = empty_o ? '0 : mem_q[rd_ptr_q];

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_drop_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o);
  p_empty_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> empty_o);
  p_new_msg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_msg_o |=> count_o == CW'(1));
  p_not_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_full_o |=> count_o == CW'(DEPTH - 1));

endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
  parameter int NB = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] set_i,
  input  logic          stat_clr_we_i,
  input  logic          en_wr_we_i,
  input  logic          en_set_we_i,
  input  logic          en_clr_we_i,
  input  logic [NB-1:0] wdata_i,
  output logic [NB-1:0] stat_o,
  output logic [NB-1:0] en_o,
  output logic          irq_o
);

  logic [NB-1:0] stat_q, en_q, stat_d, en_d;
  logic          irq_q;

  always_comb begin
    // a new event in the acknowledge cycle stays latched
    stat_d = (stat_q & ~(stat_clr_we_i ? wdata_i : '0)) | set_i;
    en_d   = en_q;
    if (en_wr_we_i)       en_d = wdata_i;
    else if (en_set_we_i) en_d = en_q | wdata_i;
    else if (en_clr_we_i) en_d = en_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      irq_q  <= |(stat_q & en_q);
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_we_i && (set_i == '0) |=> (stat_o & $past(wdata_i)) == '0);
  p_en_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_we_i && !en_wr_we_i && !en_set_we_i |=> (en_o & $past(wdata_i)) == '0);
  p_irq_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o & en_o) != '0 |=> irq_o);
  p_irq_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o & en_o) == '0 |=> !irq_o);

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl #(
  parameter int                    DW     = 32,
  parameter int                    AW     = 12,
  parameter int                    N_FIFO = 4,
  parameter int                    N_USER = 2,
  parameter int                    DEPTH  = 4,
  parameter logic [31:0]           REV_ID = 32'h0000_0400,
  parameter mbox_pkg::irq_layout_e LAYOUT = mbox_pkg::LAYOUT_SPLIT,
  localparam int NB = 2 * N_FIFO,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              re_i,
  output logic [DW-1:0]     rdata_o,
  output logic [N_USER-1:0] irq_o
);
  import mbox_pkg::*;

  logic [N_FIFO-1:0] msg_hit, push, pop, full, empty, new_msg, not_full;
  logic [DW-1:0]     fifo_rd [N_FIFO];
  logic [CW-1:0]     cnt     [N_FIFO];
  logic [NB-1:0]     ev_set;
  logic [NB-1:0]     stat    [N_USER];
  logic [NB-1:0]     en      [N_USER];
  logic [N_USER-1:0] stat_hit, en_hit, clr_hit;
  int unsigned       addr_w;

  assign addr_w = int'(addr_i);

  for (genvar m = 0; m < N_FIFO; m++) begin : g_fifo
    assign msg_hit[m] = (addr_w == MSG_BASE + 4 * m);
    assign push[m]    = we_i && msg_hit[m];
    assign pop[m]     = re_i && !we_i && msg_hit[m];
    assign ev_set[2*m]   = new_msg[m];
    assign ev_set[2*m+1] = not_full[m];

    mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push[m]),
      .pop_i      (pop[m]),
      .wdata_i    (wdata_i),
      .rdata_o    (fifo_rd[m]),
      .count_o    (cnt[m]),
      .full_o     (full[m]),
      .empty_o    (empty[m]),
      .new_msg_o  (new_msg[m]),
      .not_full_o (not_full[m])
    );
  end

  for (genvar u = 0; u < N_USER; u++) begin : g_user
    logic en_wr_we, en_set_we, en_clr_we;

    assign stat_hit[u] = (addr_w == stat_off(LAYOUT, u));
    assign en_hit[u]   = (addr_w == en_off(LAYOUT, u));

    if (LAYOUT == LAYOUT_SPLIT) begin : g_split
      assign clr_hit[u] = (addr_w == clr_off(u));
      assign en_wr_we   = 1'b0;
      assign en_set_we  = we_i && en_hit[u];
      assign en_clr_we  = we_i && clr_hit[u];
    end else begin : g_legacy
      assign clr_hit[u] = 1'b0;
      assign en_wr_we   = we_i && en_hit[u];
      assign en_set_we  = 1'b0;
      assign en_clr_we  = 1'b0;
    end

    mbox_user_irq #(.NB(NB)) u_irq (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .set_i         (ev_set),
      .stat_clr_we_i (we_i && stat_hit[u]),
      .en_wr_we_i    (en_wr_we),
      .en_set_we_i   (en_set_we),
      .en_clr_we_i   (en_clr_we),
      .wdata_i       (wdata_i[NB-1:0]),
      .stat_o        (stat[u]),
      .en_o          (en[u]),
      .irq_o         (irq_o[u])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_w == REV_OFF) rdata_o = DW'(REV_ID);
    for (int m = 0; m < N_FIFO; m++) begin
      if (msg_hit[m])                        rdata_o = fifo_rd[m];
      if (addr_w == FULL_BASE + 4 * m)       rdata_o = DW'(full[m]);
      if (addr_w == CNT_BASE + 4 * m)        rdata_o = DW'(cnt[m]);
    end
    for (int u = 0; u < N_USER; u++) begin
      if (stat_hit[u])              rdata_o = DW'(stat[u]);
      if (en_hit[u] || clr_hit[u])  rdata_o = DW'(en[u]);
    end
  end

  p_pop_one_hot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop | push));
  p_empty_rd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_hit & empty) != '0 |-> rdata_o == '0);

endmodule

// File: tb/mbox_ctrl_bench.sv
module mbox_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_FIFO = 4;
  localparam int N_USER = 2;
  localparam int DEPTH  = 4;
  localparam logic [31:0] REV = 32'h0000_0400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [11:0] addr [2];
  logic        we   [2];
  logic        re   [2];
  logic [31:0] wd   [2];
  logic [31:0] rd   [2];
  logic [N_USER-1:0] irq [2];

  int n_chk = 0;
  int n_bad = 0;

  mbox_ctrl #(.LAYOUT(mbox_pkg::LAYOUT_SPLIT)) u_mbox_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr[0]), .we_i(we[0]),
    .wdata_i(wd[0]), .re_i(re[0]), .rdata_o(rd[0]), .irq_o(irq[0]));

  mbox_ctrl #(.LAYOUT(mbox_pkg::LAYOUT_LEGACY)) u_mbox_ctrl_legacy (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr[1]), .we_i(we[1]),
    .wdata_i(wd[1]), .re_i(re[1]), .rdata_o(rd[1]), .irq_o(irq[1]));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int s, int a, logic [31:0] d);
    @(negedge clk);
    addr[s] = 12'(a); wd[s] = d; we[s] = 1'b1;
    @(posedge clk); #1;
    we[s] = 1'b0;
  endtask

  task automatic rdx(int s, int a, output logic [31:0] d);
    @(negedge clk);
    addr[s] = 12'(a); re[s] = 1'b1;
    #1 d = rd[s];
    @(posedge clk); #1;
    re[s] = 1'b0;
  endtask

  task automatic rchk(int s, int a, logic [31:0] exp, string req);
    logic [31:0] d;
    rdx(s, a, d);
    chk(req, d, exp);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int st_a(int s, int u);
    return (s == 0) ? ('h104 + 'h10 * u) : ('h100 + 8 * u);
  endfunction
  function automatic int en_a(int s, int u);
    return (s == 0) ? ('h108 + 'h10 * u) : ('h104 + 8 * u);
  endfunction
  function automatic logic [31:0] word(int m, int k);
    return 32'hA5C0_0000 | (m << 8) | k;
  endfunction

  // fill, overflow, drain and underflow of one queue
  task automatic sweep(int s, int m);
    for (int k = 0; k <= DEPTH; k++) begin
      int exp_cnt = (k + 1 > DEPTH) ? DEPTH : k + 1;
      wr(s, 'h040 + 4 * m, word(m, k));
      rchk(s, 'h0C0 + 4 * m, 32'(exp_cnt), "R5 count");
      rchk(s, 'h080 + 4 * m, (k + 1 >= DEPTH) ? 32'd1 : 32'd0, "R4 full flag");
      if (k == 0) begin
        for (int u = 0; u < N_USER; u++)
          rchk(s, st_a(s, u), 32'(1) << (2 * m), "R6 new-message bit");
        wr(s, st_a(s, 0), 32'h0);
        rchk(s, st_a(s, 0), 32'(1) << (2 * m), "R8 write 0 keeps");
        for (int u = 0; u < N_USER; u++) begin
          wr(s, st_a(s, u), 32'(1) << (2 * m));
          rchk(s, st_a(s, u), 32'h0, "R8 ack clears");
        end
      end else begin
        rchk(s, st_a(s, 1), 32'h0, "R6 no event on non-empty push");
      end
    end
    rchk(s, 'h0C0 + 4 * m, 32'(DEPTH), "R3 overflow dropped");
    for (int k = 0; k < DEPTH; k++) begin
      rchk(s, 'h040 + 4 * m, word(m, k), "R2 order");
      if (k == 0) begin
        for (int u = 0; u < N_USER; u++) begin
          rchk(s, st_a(s, u), 32'(1) << (2 * m + 1), "R7 not-full bit");
          wr(s, st_a(s, u), 32'(1) << (2 * m + 1));
        end
      end else begin
        rchk(s, st_a(s, 0), 32'h0, "R7 no event when not full");
      end
    end
    rchk(s, 'h040 + 4 * m, 32'h0, "R3 empty read zero");
    rchk(s, 'h0C0 + 4 * m, 32'h0, "R3 empty count");
    rchk(s, 'h080 + 4 * m, 32'h0, "R4 not full");
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      addr[s] = '0; we[s] = 1'b0; re[s] = 1'b0; wd[s] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int s = 0; s < 2; s++) begin
      chk("R1 irq at reset", 32'(irq[s]), 32'h0);
      rchk(s, 'h000, REV, "R1 revision");
      wr(s, 'h000, 32'hFFFF_FFFF);
      rchk(s, 'h000, REV, "R1 revision read-only");
      for (int m = 0; m < N_FIFO; m++) begin
        rchk(s, 'h0C0 + 4 * m, 32'h0, "R1 count reset");
        rchk(s, 'h080 + 4 * m, 32'h0, "R1 full reset");
      end
      for (int u = 0; u < N_USER; u++) begin
        rchk(s, st_a(s, u), 32'h0, "R1 status reset");
        rchk(s, en_a(s, u), 32'h0, "R1 enable reset");
      end
    end

    for (int s = 0; s < 2; s++)
      for (int m = 0; m < N_FIFO; m++)
        sweep(s, m);

    // split layout enable set / clear and interrupt timing
    wr(0, 'h108, 32'h1);
    wr(0, 'h108, 32'h4);
    rchk(0, 'h108, 32'h5, "R10 enable-set ORs");
    rchk(0, 'h10C, 32'h5, "R10 enable-clear reads enable");
    wr(0, 'h040, 32'h1234_5678);
    chk("R9 irq not before latency", 32'(irq[0]), 32'h0);
    tick();
    chk("R9 irq high", 32'(irq[0]), 32'h1);
    wr(0, 'h10C, 32'h1);
    rchk(0, 'h108, 32'h4, "R10 enable-clear");
    chk("R9 irq low after disable", 32'(irq[0]), 32'h0);
    rchk(0, 'h104, 32'h1, "R10 status kept after disable");
    wr(0, 'h108, 32'h1);
    tick();
    chk("R9 irq back", 32'(irq[0]), 32'h1);
    wr(0, 'h104, 32'h1);
    rchk(0, 'h104, 32'h0, "R8 immediate readback");
    chk("R9 irq low after ack", 32'(irq[0]), 32'h0);
    rchk(0, 'h040, 32'h1234_5678, "R2 single word");

    // legacy direct enable write and user 1 interrupt
    wr(1, 'h10C, 32'h3);
    wr(1, 'h10C, 32'h4);
    rchk(1, 'h10C, 32'h4, "R11 enable replaced");
    wr(1, 'h044, 32'hCAFE_0001);
    tick();
    chk("R11 user1 irq", 32'(irq[1]), 32'h2);
    rchk(1, 'h108, 32'h4, "R11 user1 status");
    wr(1, 'h108, 32'h4);
    tick();
    chk("R11 irq cleared", 32'(irq[1]), 32'h0);
    rchk(1, 'h044, 32'hCAFE_0001, "R2 legacy pop");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule